// File: doc/BRIEF.md
# Three-Level Matrix Converter Gate Sequencer

This block drives the twelve gate enables of a four-by-three bidirectional switch array. Three rows connect to the input phases A, B and C, and a fourth row connects to the neutral star point of the input filter. The three columns are the output phases a, b and c. The block receives the modulation decisions for one sampling period and plays them out as a timed sequence of switch patterns. Those decisions are the rectifier region, the two candidate long vectors, the two candidate virtual short vectors, the pair of adjacent inverter active vectors, three rectifier dwell times in clock cycles, and the share of each dwell given to the first inverter vector.

Each switch pattern is the product of a rectifier state and an inverter state. The rectifier state picks which input row feeds the positive rail and which feeds the negative rail. The inverter state routes each output column to one of those two rails. A virtual short vector never appears as such. Its dwell is split into two halves, one for each of the two real short vectors on either side of it, so that the neutral current cancels over the period. The inverter uses only its two active vectors. A sample strobe marks each period boundary, and new settings act only from a strobe. A per-column legality guard refuses any pattern that would short inputs or open an output.

Top module: `tmc_gate_seq`

## Requirements
- R1: While reset is asserted, every output column connects to the neutral row, so `gate_en` is 12'hE00 (bit index = row*3 + column, rows A=0, B=1, C=2, N=3, columns a=0, b=1, c=2), and `pattern_err` is 0.
- R2: In every cycle, exactly one of the four gate bits of each output column is set.
- R3: A slot's pattern connects column c to the positive-rail row when the inverter mask bit c is 1, and to the negative-rail row otherwise. Long vector codes 0..5 map to rail pairs (positive,negative) AB, AC, BC, BA, CA, CB. Short codes 0..5 map to AN, NC, BN, NA, CN, NB. Inverter codes 0..5 map to masks 001, 011, 010, 110, 100, 101 (bit 0 = column a). The zero vector puts both rails on N.
- R4: A virtual short vector of code v (0..5) spends floor(D/2) cycles on short code (v+5) mod 6 and then D-floor(D/2) cycles on short code v, where D is its dwell.
- R5: Region codes 0..4 (R1..R5) play these sequences. Region 0: long_a for dwell 1, virtual_a for dwell 2, long_b for dwell 3. Region 1: long_a, virtual_b, long_b. Region 2: long_a, virtual_a, virtual_b. Region 3: long_b, virtual_a, virtual_b. Region 4 and above: zero vector, virtual_a, virtual_b.
- R6: Each rectifier sub-slot of length L shows the inverter gamma vector for floor(L*gamma_frac/256) cycles, then the delta vector for the rest. No inverter zero vector is ever used.
- R7: Slots of zero length are skipped without occupying any cycle.
- R8: The first slot appears on `gate_en` two cycles after the clock edge that samples `sample_stb`. Each slot lasts exactly its length. After the last slot, the final pattern holds until the next strobe.
- R9: Input changes without a strobe have no effect on `gate_en`. A strobe during a period abandons it and starts the new one.
- R10: When a slot decodes to an illegal pattern (any vector code 6 or 7), `gate_en` keeps its previous value and `pattern_err` is 1 for each such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb | input | 1 | Period boundary strobe that latches all settings |
| region_sel | input | 3 | Rectifier region code, 0..4 for R1..R5 |
| rl_first | input | 3 | First long vector code |
| rl_second | input | 3 | Second long vector code |
| rv_first | input | 3 | First virtual short vector code |
| rv_second | input | 3 | Second virtual short vector code |
| iv_gamma | input | 3 | Inverter vector applied first in each sub-slot |
| iv_delta | input | 3 | Inverter vector applied second in each sub-slot |
| dwell_1 | input | DUR_W | Cycles for the first rectifier vector |
| dwell_2 | input | DUR_W | Cycles for the second rectifier vector |
| dwell_3 | input | DUR_W | Cycles for the third rectifier vector |
| gamma_frac | input | FRAC_W | Share of each sub-slot given to the gamma vector, in 1/256 |
| gate_en | output | 12 | Switch enables, index row*3 + column |
| pattern_err | output | 1 | High in cycles where an illegal pattern was refused |

## Verification
The assertions check four things on every clock: each output column has exactly one active gate, a refused pattern leaves the gates unchanged, an active slot never has zero length or zero remaining count, and a strobe stops the running period at the next edge. These hold for any vector codes. They cannot show that the right vector appears at the right moment. The directed scenarios show that part. They cover the order of virtual-vector halves, the per-region vector sets, how rounding splits odd dwells and inverter shares, the skipping of empty slots, the hold after the period, the restart on a mid-period strobe, and the fact that settings changed without a strobe have no effect.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  localparam int ROWS      = 4;
  localparam int COLS      = 3;
  localparam int GATES     = ROWS * COLS;
  localparam int SUB_SLOTS = 5;
  localparam int SLOTS     = 2 * SUB_SLOTS;
  localparam int SLOT_W    = $clog2(SLOTS);

  localparam logic [3:0] ROW_A = 4'b0001;
  localparam logic [3:0] ROW_B = 4'b0010;
  localparam logic [3:0] ROW_C = 4'b0100;
  localparam logic [3:0] ROW_N = 4'b1000;

  // rectifier state: one-hot rows feeding the positive and negative rail
  typedef struct packed {
    logic [3:0] p_oh;
    logic [3:0] n_oh;
  } rect_t;

  // inverter state: columns routed to the positive or the negative rail
  typedef struct packed {
    logic [2:0] to_p;
    logic [2:0] to_n;
  } inv_t;

  function automatic rect_t mk_rect(logic [3:0] p, logic [3:0] n);
    rect_t r;
    r.p_oh = p;
    r.n_oh = n;
    return r;
  endfunction

  function automatic rect_t rect_long(logic [2:0] code);
    case (code)
      3'd0:    return mk_rect(ROW_A, ROW_B);
      3'd1:    return mk_rect(ROW_A, ROW_C);
      3'd2:    return mk_rect(ROW_B, ROW_C);
      3'd3:    return mk_rect(ROW_B, ROW_A);
      3'd4:    return mk_rect(ROW_C, ROW_A);
      3'd5:    return mk_rect(ROW_C, ROW_B);
      default: return mk_rect(4'b0000, 4'b0000);
    endcase
  endfunction

  function automatic rect_t rect_short(logic [2:0] code);
    case (code)
      3'd0:    return mk_rect(ROW_A, ROW_N);
      3'd1:    return mk_rect(ROW_N, ROW_C);
      3'd2:    return mk_rect(ROW_B, ROW_N);
      3'd3:    return mk_rect(ROW_N, ROW_A);
      3'd4:    return mk_rect(ROW_C, ROW_N);
      3'd5:    return mk_rect(ROW_N, ROW_B);
      default: return mk_rect(4'b0000, 4'b0000);
    endcase
  endfunction

  function automatic rect_t rect_zero();
    return mk_rect(ROW_N, ROW_N);
  endfunction

  // half 0 uses the preceding short vector, half 1 the vector's own index
  function automatic rect_t virt_half(logic [2:0] code, logic second);
    if (code > 3'd5) return mk_rect(4'b0000, 4'b0000);
    if (second)      return rect_short(code);
    return rect_short((code == 3'd0) ? 3'd5 : code - 3'd1);
  endfunction

  function automatic inv_t inv_vec(logic [2:0] code);
    inv_t v;
    case (code)
      3'd0:    v.to_p = 3'b001;
      3'd1:    v.to_p = 3'b011;
      3'd2:    v.to_p = 3'b010;
      3'd3:    v.to_p = 3'b110;
      3'd4:    v.to_p = 3'b100;
      3'd5:    v.to_p = 3'b101;
      default: v.to_p = 3'b000;
    endcase
    v.to_n = (code > 3'd5) ? 3'b000 : ~v.to_p;
    return v;
  endfunction

  function automatic logic onehot4(logic [3:0] x);
    return (x != 4'b0000) && ((x & (x - 4'd1)) == 4'b0000);
  endfunction

endpackage

// File: rtl/tmc_slot_plan.sv
module tmc_slot_plan
  import tmc_pkg::*;
#(
  parameter int DUR_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic [2:0]       region,
  input  logic [2:0]       long_a,
  input  logic [2:0]       long_b,
  input  logic [2:0]       virt_a,
  input  logic [2:0]       virt_b,
  input  logic [2:0]       inv_g,
  input  logic [2:0]       inv_d,
  input  logic [DUR_W-1:0] dur1,
  input  logic [DUR_W-1:0] dur2,
  input  logic [DUR_W-1:0] dur3,
  input  logic [FRAC_W-1:0] frac,
  output logic [DUR_W-1:0] slot_len  [SLOTS],
  output rect_t            slot_rect [SLOTS],
  output inv_t             slot_inv  [SLOTS]
);

  localparam int PW = DUR_W + FRAC_W;

  logic [DUR_W-1:0] sub_len  [SUB_SLOTS];
  rect_t            sub_rect [SUB_SLOTS];
  logic             single_virt;
  logic [2:0]       mid_v;

  always_comb begin
    single_virt = (region == 3'd0) || (region == 3'd1);
    mid_v       = (region == 3'd1) ? virt_b : virt_a;

    case (region)
      3'd0, 3'd1, 3'd2: sub_rect[0] = rect_long(long_a);
      3'd3:             sub_rect[0] = rect_long(long_b);
      default:          sub_rect[0] = rect_zero();
    endcase
    sub_len[0] = dur1;

    sub_rect[1] = virt_half(mid_v, 1'b0);
    sub_len[1]  = dur2 >> 1;
    sub_rect[2] = virt_half(mid_v, 1'b1);
    sub_len[2]  = dur2 - (dur2 >> 1);

    if (single_virt) begin
      sub_rect[3] = rect_long(long_b);
      sub_len[3]  = dur3;
      sub_rect[4] = rect_zero();
      sub_len[4]  = '0;
    end else begin
      sub_rect[3] = virt_half(virt_b, 1'b0);
      sub_len[3]  = dur3 >> 1;
      sub_rect[4] = virt_half(virt_b, 1'b1);
      sub_len[4]  = dur3 - (dur3 >> 1);
    end
  end

  // each rectifier sub-slot is shared by the gamma and delta inverter vectors
  for (genvar i = 0; i < SUB_SLOTS; i++) begin : g_split
    logic [PW-1:0]    prod;
    logic [DUR_W-1:0] g_len;
    assign prod  = PW'(sub_len[i]) * PW'(frac);
    assign g_len = prod[PW-1:FRAC_W];

    assign slot_len[2*i]    = g_len;
    assign slot_len[2*i+1]  = sub_len[i] - g_len;
    assign slot_rect[2*i]   = sub_rect[i];
    assign slot_rect[2*i+1] = sub_rect[i];
    assign slot_inv[2*i]    = inv_vec(inv_g);
    assign slot_inv[2*i+1]  = inv_vec(inv_d);
  end

endmodule

// File: rtl/tmc_slot_timer.sv
module tmc_slot_timer
  import tmc_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DUR_W-1:0]  slot_len [SLOTS],
  output logic              active,
  output logic [SLOT_W-1:0] idx
);

  logic              act_q, act_d;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic [DUR_W-1:0]  rem_q, rem_d;
  logic              first_ok, next_ok;
  logic [SLOT_W-1:0] first_idx, next_idx;

  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (slot_len[i] != '0) begin
        first_ok  = 1'b1;
        first_idx = SLOT_W'(i);
        if (i > int'(idx_q)) begin
          next_ok  = 1'b1;
          next_idx = SLOT_W'(i);
        end
      end
    end
  end

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    rem_d = rem_q;
    if (start) begin
      act_d = first_ok;
      idx_d = first_idx;
      rem_d = slot_len[first_idx];
    end else if (abort) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (rem_q > DUR_W'(1)) begin
        rem_d = rem_q - DUR_W'(1);
      end else if (next_ok) begin
        idx_d = next_idx;
        rem_d = slot_len[next_idx];
      end else begin
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      rem_q <= rem_d;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;

  assert_live_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> rem_q != '0);

  assert_no_empty_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> slot_len[idx_q] != '0);

  assert_strobe_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !act_q);

endmodule

// File: rtl/tmc_gate_guard.sv
module tmc_gate_guard
  import tmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  rect_t            rect,
  input  inv_t             inv,
  output logic [GATES-1:0] gate,
  output logic             err
);

  localparam logic [GATES-1:0] GATE_RST = {COLS'('1), {(GATES-COLS){1'b0}}};

  logic [GATES-1:0] cand;
  logic [COLS-1:0]  col_ok;
  logic             legal;
  logic [GATES-1:0] gate_q, gate_d;
  logic             err_q, err_d;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cand[r*COLS+c] = (inv.to_p[c] & rect.p_oh[r]) | (inv.to_n[c] & rect.n_oh[r]);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_chk
    assign col_ok[c] = onehot4({cand[3*COLS+c], cand[2*COLS+c], cand[COLS+c], cand[c]});
  end
  assign legal = &col_ok;

  always_comb begin
    gate_d = gate_q;
    err_d  = 1'b0;
    if (active) begin
      if (legal) gate_d = cand;
      else       err_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= GATE_RST;
      err_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      err_q  <= err_d;
    end
  end

  assign gate = gate_q;
  assign err  = err_q;

  for (genvar c = 0; c < COLS; c++) begin : g_sva
    assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      onehot4({gate_q[3*COLS+c], gate_q[2*COLS+c], gate_q[COLS+c], gate_q[c]}));
  end

  assert_hold_on_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> gate_q == $past(gate_q));

endmodule

// File: rtl/tmc_gate_seq.sv
module tmc_gate_seq
  import tmc_pkg::*;
#(
  parameter int DUR_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [2:0]        region_sel,
  input  logic [2:0]        rl_first,
  input  logic [2:0]        rl_second,
  input  logic [2:0]        rv_first,
  input  logic [2:0]        rv_second,
  input  logic [2:0]        iv_gamma,
  input  logic [2:0]        iv_delta,
  input  logic [DUR_W-1:0]  dwell_1,
  input  logic [DUR_W-1:0]  dwell_2,
  input  logic [DUR_W-1:0]  dwell_3,
  input  logic [FRAC_W-1:0] gamma_frac,
  output logic [11:0]       gate_en,
  output logic              pattern_err
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ln = rst_sync[1];

  // period settings, captured only at the strobe
  logic [2:0]        reg_q, la_q, lb_q, va_q, vb_q, ig_q, id_q;
  logic [DUR_W-1:0]  d1_q, d2_q, d3_q;
  logic [FRAC_W-1:0] fr_q;
  logic              start_q;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      reg_q <= '0; la_q <= '0; lb_q <= '0; va_q <= '0; vb_q <= '0;
      ig_q  <= '0; id_q <= '0;
      d1_q  <= '0; d2_q <= '0; d3_q <= '0;
      fr_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= sample_stb;
      if (sample_stb) begin
        reg_q <= region_sel; la_q <= rl_first; lb_q <= rl_second;
        va_q  <= rv_first;   vb_q <= rv_second;
        ig_q  <= iv_gamma;   id_q <= iv_delta;
        d1_q  <= dwell_1;    d2_q <= dwell_2;  d3_q <= dwell_3;
        fr_q  <= gamma_frac;
      end
    end
  end

  logic [DUR_W-1:0]  slot_len  [SLOTS];
  rect_t             slot_rect [SLOTS];
  inv_t              slot_inv  [SLOTS];
  logic              active;
  logic [SLOT_W-1:0] idx;

  tmc_slot_plan #(.DUR_W(DUR_W), .FRAC_W(FRAC_W)) u_plan (
    .region   (reg_q),
    .long_a   (la_q),
    .long_b   (lb_q),
    .virt_a   (va_q),
    .virt_b   (vb_q),
    .inv_g    (ig_q),
    .inv_d    (id_q),
    .dur1     (d1_q),
    .dur2     (d2_q),
    .dur3     (d3_q),
    .frac     (fr_q),
    .slot_len (slot_len),
    .slot_rect(slot_rect),
    .slot_inv (slot_inv)
  );

  tmc_slot_timer #(.DUR_W(DUR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ln),
    .start   (start_q),
    .abort   (sample_stb),
    .slot_len(slot_len),
    .active  (active),
    .idx     (idx)
  );

  tmc_gate_guard u_guard (
    .clk   (clk),
    .rst_n (rst_ln),
    .active(active),
    .rect  (slot_rect[idx]),
    .inv   (slot_inv[idx]),
    .gate  (gate_en),
    .err   (pattern_err)
  );

endmodule

// File: tb/tmc_gate_seq_tb.sv
module tmc_gate_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int FR_SH      = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_stb;
  logic [2:0]  region_sel, rl_first, rl_second, rv_first, rv_second, iv_gamma, iv_delta;
  logic [15:0] dwell_1, dwell_2, dwell_3;
  logic [7:0]  gamma_frac;
  logic [11:0] gate_en;
  logic        pattern_err;

  int n_checks = 0;
  int n_fail   = 0;

  logic [11:0] exp_g [0:511];
  logic        exp_e [0:511];
  int          exp_n;
  int          pos;
  logic [11:0] last_g;
  int          cur_fr, cur_ig, cur_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmc_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .region_sel(region_sel), .rl_first(rl_first), .rl_second(rl_second),
    .rv_first(rv_first), .rv_second(rv_second),
    .iv_gamma(iv_gamma), .iv_delta(iv_delta),
    .dwell_1(dwell_1), .dwell_2(dwell_2), .dwell_3(dwell_3),
    .gamma_frac(gamma_frac), .gate_en(gate_en), .pattern_err(pattern_err)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic void long_rows(input int c, output int p, output int n);
    case (c)
      0: begin p = 0; n = 1; end
      1: begin p = 0; n = 2; end
      2: begin p = 1; n = 2; end
      3: begin p = 1; n = 0; end
      4: begin p = 2; n = 0; end
      5: begin p = 2; n = 1; end
      default: begin p = -1; n = -1; end
    endcase
  endfunction

  function automatic void short_rows(input int c, output int p, output int n);
    case (c)
      0: begin p = 0; n = 3; end
      1: begin p = 3; n = 2; end
      2: begin p = 1; n = 3; end
      3: begin p = 3; n = 0; end
      4: begin p = 2; n = 3; end
      5: begin p = 3; n = 1; end
      default: begin p = -1; n = -1; end
    endcase
  endfunction

  function automatic logic [2:0] inv_mask(input int c);
    case (c)
      0: return 3'b001;
      1: return 3'b011;
      2: return 3'b010;
      3: return 3'b110;
      4: return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [11:0] pat(input int p, input int n, input logic [2:0] m);
    logic [11:0] g = '0;
    for (int c = 0; c < 3; c++) begin
      if (m[c]) g[p*3+c] = 1'b1;
      else      g[n*3+c] = 1'b1;
    end
    return g;
  endfunction

  task automatic add_part(input int cnt, input int p, input int n, input int iv);
    for (int j = 0; j < cnt; j++) begin
      if (p < 0) begin
        exp_g[exp_n] = last_g;
        exp_e[exp_n] = 1'b1;
      end else begin
        exp_g[exp_n] = pat(p, n, inv_mask(iv));
        exp_e[exp_n] = 1'b0;
        last_g       = exp_g[exp_n];
      end
      exp_n++;
    end
  endtask

  task automatic add_sub(input int len, input int p, input int n);
    int gl;
    gl = (len * cur_fr) >> FR_SH;
    add_part(gl, p, n, cur_ig);
    add_part(len - gl, p, n, cur_id);
  endtask

  task automatic add_virt(input int v, input int d);
    int p, n;
    if (v > 5) begin
      add_sub(d / 2, -1, -1);
      add_sub(d - d / 2, -1, -1);
    end else begin
      short_rows((v + 5) % 6, p, n);
      add_sub(d / 2, p, n);
      short_rows(v, p, n);
      add_sub(d - d / 2, p, n);
    end
  endtask

  // drive at a negedge; build expected timeline; leaves off just before first gate
  task automatic start_period(input int rg, input int la, input int lb, input int va, input int vb,
                              input int ig, input int id, input int d1, input int d2, input int d3,
                              input int fr);
    int p, n;
    region_sel = 3'(rg); rl_first = 3'(la); rl_second = 3'(lb);
    rv_first = 3'(va); rv_second = 3'(vb); iv_gamma = 3'(ig); iv_delta = 3'(id);
    dwell_1 = 16'(d1); dwell_2 = 16'(d2); dwell_3 = 16'(d3); gamma_frac = 8'(fr);
    sample_stb = 1'b1;
    cur_fr = fr; cur_ig = ig; cur_id = id;
    exp_n = 0; pos = 0;
    if (rg <= 2) long_rows(la, p, n);
    else if (rg == 3) long_rows(lb, p, n);
    else begin p = 3; n = 3; end
    add_sub(d1, p, n);
    add_virt((rg == 1) ? vb : va, d2);
    if (rg <= 1) begin
      long_rows(lb, p, n);
      add_sub(d3, p, n);
    end else begin
      add_virt(vb, d3);
    end
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_cycles(input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      n_checks++;
      if (gate_en !== exp_g[pos] || pattern_err !== exp_e[pos]) begin
        n_fail++;
        $display("FAIL %s pos %0d: gate=%h err=%b expected gate=%h err=%b",
                 req, pos, gate_en, pattern_err, exp_g[pos], exp_e[pos]);
      end
      pos++;
    end
  endtask

  task automatic check_hold(input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      n_checks++;
      if (gate_en !== last_g || pattern_err !== 1'b0) begin
        n_fail++;
        $display("FAIL %s hold %0d: gate=%h err=%b expected gate=%h err=0",
                 req, i, gate_en, pattern_err, last_g);
      end
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    n_checks++;
    if (gate_en !== 12'hE00 || pattern_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: gate=%h err=%b expected gate=e00 err=0", gate_en, pattern_err);
    end
    last_g = 12'hE00;
  endtask

  task automatic t_region1;   // R3 R4 R5 R6 R8
    start_period(0, 0, 1, 0, 3, 0, 1, 5, 7, 4, 128);
    check_cycles(exp_n, "R5_region1");
    check_hold(3, "R8_hold");
  endtask

  task automatic t_region2;   // R5 with second virtual in the middle
    start_period(1, 2, 3, 1, 3, 2, 3, 4, 6, 3, 64);
    check_cycles(exp_n, "R5_region2");
  endtask

  task automatic t_region3;
    start_period(2, 4, 0, 2, 4, 4, 5, 3, 5, 9, 200);
    check_cycles(exp_n, "R4_region3");
  endtask

  task automatic t_region4;   // gamma share zero: R6 and R7
    start_period(3, 1, 5, 5, 1, 1, 3, 6, 4, 5, 0);
    check_cycles(exp_n, "R6_region4");
  endtask

  task automatic t_region5;   // zero vector, one-cycle virtual dwell: R3 R7
    start_period(4, 0, 0, 3, 0, 5, 0, 6, 1, 2, 255);
    check_cycles(exp_n, "R3_region5");
  endtask

  task automatic t_skip;      // empty dwells skipped
    start_period(0, 3, 4, 4, 0, 2, 4, 0, 5, 0, 100);
    check_cycles(exp_n, "R7_skip");
    check_hold(2, "R7_skip_hold");
  endtask

  task automatic t_no_strobe; // R9: settings without a strobe do nothing
    region_sel = 3'd4; rl_first = 3'd5; rv_first = 3'd2; iv_gamma = 3'd3;
    dwell_1 = 16'd2; dwell_2 = 16'd2; dwell_3 = 16'd2; gamma_frac = 8'd77;
    check_hold(8, "R9_no_strobe");
  endtask

  task automatic t_restart;   // R9: strobe mid-period
    start_period(2, 0, 0, 1, 2, 0, 2, 8, 8, 8, 128);
    check_cycles(3, "R9_first");
    start_period(3, 0, 2, 4, 5, 3, 4, 3, 4, 2, 90);
    check_cycles(exp_n, "R9_restart");
  endtask

  task automatic t_illegal;   // R10
    start_period(0, 7, 2, 1, 0, 1, 2, 4, 4, 3, 128);
    check_cycles(exp_n, "R10_illegal");
    start_period(0, 2, 1, 6, 0, 0, 1, 2, 3, 2, 128);
    check_cycles(exp_n, "R10_bad_virtual");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_stb = 1'b0;
    region_sel = '0; rl_first = '0; rl_second = '0; rv_first = '0; rv_second = '0;
    iv_gamma = '0; iv_delta = '0; dwell_1 = '0; dwell_2 = '0; dwell_3 = '0; gamma_frac = '0;
    exp_n = 0; pos = 0; cur_fr = 0; cur_ig = 0; cur_id = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_region1();
    t_region2();
    t_region3();
    t_region4();
    t_region5();
    t_skip();
    t_no_strobe();
    t_restart();
    check_hold(2, "R8_after_restart");
    t_illegal();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule